// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM of 256K words by 16 bits. The host issues one word access at a time. A request carries a word address, a read/write flag, write data and a two-bit lane mask. The controller turns that request into a pin-level cycle on the memory, with active-low chip select, output enable, write strobe and per-byte lane enables. The memory data bus is split into an output value, an output enable and an input value, so the pad ring can build the tri-state bus.

Every timing window is a whole number of clock cycles, set by a parameter. The defaults fit a 10 ns memory grade behind a 250 MHz clock:

- address setup before the write strobe: 1 cycle
- write strobe width: 2 cycles (8 ns, against a 7 ns minimum)
- hold after the strobe: 1 cycle
- read access: 3 cycles (12 ns, against a 10 ns access time)
- bus release after a read: 1 cycle

The controller drives the data bus only while the write strobe is low. It keeps output enable high through every write, so its drivers and the memory's drivers never overlap.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `rd_valid` is 0 and `dq_oe` is 0, and `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_lb_n` and `mem_ub_n` are all 1.
- R2: The write strobe is timed as follows.
  - On a write, `mem_ce_n` goes low and the address and lane enables appear on the edge that accepts the request.
  - `mem_we_n` falls SETUP_CYC cycles later and stays low for exactly WE_CYC cycles.
  - The address and lane enables do not change while `mem_we_n` is low.
- R3: Lane mask bit 0 controls `mem_lb_n`, which covers data bits 7:0. Mask bit 1 controls `mem_ub_n`, which covers data bits 15:8. A lane enable is driven low exactly when its mask bit is 1, and only the selected lanes of the memory word change.
- R4: `dq_oe` is 1 exactly while `mem_we_n` is low, and `mem_oe_n` stays 1 for the whole of a write cycle.
- R5: A read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for RD_CYC cycles. The controller samples `dq_in` on the RD_CYC-th edge after the accepting edge. `rd_valid` is high for exactly one cycle, starting at that same edge.
- R6: In `rd_data`, any byte lane whose mask bit was 0 on the read request reads as 8'h00.
- R7: `ready` is 1 only in idle and is low from the accepting edge until the cycle is over.
  - A write keeps `ready` low for SETUP_CYC+WE_CYC+HOLD_CYC cycles.
  - A read keeps `ready` low for RD_CYC+GAP_CYC cycles.
  - A request presented while `ready` is 0 is ignored.
- R8: When read data is captured, `mem_ce_n` and `mem_oe_n` are already back high. `dq_oe` is never 1 while the memory is selected for a read.
- R9: A write with mask 2'b00 keeps both lane enables high, so the stored word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, taken when `ready` is 1 |
| req_write | input | 1 | 1 selects a write, 0 selects a read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask: bit 0 is the low byte, bit 1 is the high byte |
| ready | output | 1 | Controller idle and able to accept a request |
| rd_data | output | 16 | Read data, with unselected lanes set to zero |
| rd_valid | output | 1 | One-cycle pulse marking valid `rd_data` |
| mem_addr | output | 18 | Memory address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_lb_n | output | 1 | Low byte lane enable, active low |
| mem_ub_n | output | 1 | High byte lane enable, active low |
| dq_out | output | 16 | Value driven onto the data bus |
| dq_oe | output | 1 | Data bus driver enable |
| dq_in | input | 16 | Value sampled from the data bus |

## Verification
Two situations are hard to reach from the ports.

The first is a request held high while a cycle is still in flight. The bench raises `req` with a different address and data just after a write has been accepted. It drops `req` before `ready` returns, then reads that address back to show nothing was written.

The second is a read sampled too early. The bench's memory model returns a garbage pattern until the select has been low for two full clock periods. Any shortened access window therefore shows up as wrong read data. The same model flags any overlap of the controller's drivers with its own read drive.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_SETUP,
    ST_W_PULSE,
    ST_W_HOLD,
    ST_R_ACCESS,
    ST_R_GAP
  } seq_state_t;

endpackage

// File: rtl/sram_step_timer.sv
// Down counter for the length of one phase: load N-1 on entry, done at zero.
module sram_step_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
// Phase sequencer: owns the control strobes and the ready flag.
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 2,
  parameter int HOLD_CYC  = 1,
  parameter int RD_CYC    = 3,
  parameter int GAP_CYC   = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic req_write,
  output logic ready,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic accept,
  output logic strobe_on,
  output logic strobe_off,
  output logic capture,
  output logic release_bus
);

  localparam int M1    = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
  localparam int M2    = (HOLD_CYC > RD_CYC) ? HOLD_CYC : RD_CYC;
  localparam int M3    = (M1 > M2) ? M1 : M2;
  localparam int MAXC  = (M3 > GAP_CYC) ? M3 : GAP_CYC;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

  seq_state_t       state;
  logic             done;
  logic             load;
  logic [CNT_W-1:0] load_val;

  sram_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .done     (done)
  );

  assign accept      = (state == ST_IDLE) && req;
  assign strobe_on   = (state == ST_W_SETUP) && done;
  assign strobe_off  = (state == ST_W_PULSE) && done;
  assign capture     = (state == ST_R_ACCESS) && done;
  assign release_bus = ((state == ST_W_HOLD) && done) || capture;

  always_comb begin
    load     = 1'b0;
    load_val = '0;
    if (accept) begin
      load     = 1'b1;
      load_val = req_write ? CNT_W'(SETUP_CYC - 1) : CNT_W'(RD_CYC - 1);
    end else if (strobe_on) begin
      load     = 1'b1;
      load_val = CNT_W'(WE_CYC - 1);
    end else if (strobe_off) begin
      load     = 1'b1;
      load_val = CNT_W'(HOLD_CYC - 1);
    end else if (capture) begin
      load     = 1'b1;
      load_val = CNT_W'(GAP_CYC - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ready <= 1'b1;
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (req) begin
          ce_n  <= 1'b0;
          oe_n  <= req_write;
          ready <= 1'b0;
          state <= req_write ? ST_W_SETUP : ST_R_ACCESS;
        end
        ST_W_SETUP: if (done) begin
          we_n  <= 1'b0;
          state <= ST_W_PULSE;
        end
        ST_W_PULSE: if (done) begin
          we_n  <= 1'b1;
          state <= ST_W_HOLD;
        end
        ST_W_HOLD: if (done) begin
          ce_n  <= 1'b1;
          ready <= 1'b1;
          state <= ST_IDLE;
        end
        ST_R_ACCESS: if (done) begin
          ce_n  <= 1'b1;
          oe_n  <= 1'b1;
          state <= ST_R_GAP;
        end
        ST_R_GAP: if (done) begin
          ready <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_data_lanes.sv
// Address, lane-enable and data registers, with per-lane read capture.
module sram_data_lanes #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic              strobe_on,
  input  logic              strobe_off,
  input  logic              capture,
  input  logic              release_bus,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  ben_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [LANES-1:0]      lane_sel;
  logic [LANES-1:0][7:0] lane_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      ben_n    <= '1;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
      rd_valid <= 1'b0;
      lane_sel <= '0;
    end else begin
      rd_valid <= capture;
      if (accept) begin
        mem_addr <= req_addr;
        ben_n    <= ~req_mask;
        dq_out   <= req_wdata;
        lane_sel <= req_mask;
      end
      if (strobe_on)   dq_oe <= 1'b1;
      if (strobe_off)  dq_oe <= 1'b0;
      if (release_bus) ben_n <= '1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q[g] <= 8'h00;
      end else if (capture) begin
        lane_q[g] <= lane_sel[g] ? dq_in[g*8 +: 8] : 8'h00;
      end
    end
  end

  assign rd_data = lane_q;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 2,
  parameter int HOLD_CYC  = 1,
  parameter int RD_CYC    = 3,
  parameter int GAP_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_mask,
  output logic              ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);

  localparam int LANES = DATA_W / 8;

  logic             accept;
  logic             strobe_on;
  logic             strobe_off;
  logic             capture;
  logic             release_bus;
  logic [LANES-1:0] ben_n;

  sram_seq_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .WE_CYC    (WE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .RD_CYC    (RD_CYC),
    .GAP_CYC   (GAP_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .req_write   (req_write),
    .ready       (ready),
    .ce_n        (mem_ce_n),
    .oe_n        (mem_oe_n),
    .we_n        (mem_we_n),
    .accept      (accept),
    .strobe_on   (strobe_on),
    .strobe_off  (strobe_off),
    .capture     (capture),
    .release_bus (release_bus)
  );

  sram_data_lanes #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_lanes (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_mask    (req_mask),
    .strobe_on   (strobe_on),
    .strobe_off  (strobe_off),
    .capture     (capture),
    .release_bus (release_bus),
    .dq_in       (dq_in),
    .mem_addr    (mem_addr),
    .ben_n       (ben_n),
    .dq_out      (dq_out),
    .dq_oe       (dq_oe),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid)
  );

  assign mem_lb_n = ben_n[0];
  assign mem_ub_n = ben_n[LANES-1];

endmodule

// File: rtl/sram_async_ctrl_checker.sv
module sram_async_ctrl_checker #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic              dq_oe
);

  // R2: address and lanes frozen while the strobe is low
  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable({mem_ub_n, mem_lb_n})));

  // R4: drivers on only inside the strobe
  assert_drive_in_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    dq_oe == !mem_we_n);

  // R4: output enable high during the strobe
  assert_oe_off_in_write_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  // R5: valid lasts one cycle
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R8: no driver while the memory may drive
  assert_no_contention_R8: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !mem_oe_n) |-> !dq_oe);

  // R7: idle means the bus is quiet
  assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    ready |-> (mem_ce_n && mem_we_n && mem_oe_n));

  // R3: lanes closed when the chip is deselected
  assert_lanes_closed_R3: assert property (@(posedge clk) disable iff (rst)
    mem_ce_n |-> (mem_lb_n && mem_ub_n));

endmodule

bind sram_async_ctrl sram_async_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        ready;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  logic [15:0] dq_out;
  logic        dq_oe;
  logic [15:0] dq_in;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sram_async_ctrl uut (.*);

  // ---------------- memory model ----------------
  logic [15:0] mem [256];
  int          rd_age = 0;
  logic        rd_active;

  function automatic logic [15:0] init_word(int i);
    return (16'(i) * 16'h0101) ^ 16'h5A3C;
  endfunction

  initial for (int i = 0; i < 256; i++) mem[i] = init_word(i);

  assign rd_active = !mem_ce_n && !mem_oe_n && mem_we_n;

  always @(posedge clk) rd_age <= rd_active ? ((rd_age < 100) ? rd_age + 1 : rd_age) : 0;

  always_comb begin
    dq_in = 16'hEEEE;
    if (rd_active && rd_age >= 2) begin
      if (!mem_lb_n) dq_in[7:0]  = mem[mem_addr[7:0]][7:0];
      if (!mem_ub_n) dq_in[15:8] = mem[mem_addr[7:0]][15:8];
    end
  end

  always @(posedge mem_we_n) begin
    if (!mem_ce_n) begin
      if (!mem_lb_n) mem[mem_addr[7:0]][7:0]  <= dq_out[7:0];
      if (!mem_ub_n) mem[mem_addr[7:0]][15:8] <= dq_out[15:8];
    end
  end

  // ---------------- pin monitors (sampled at negedge) ----------------
  int          we_run = 0, last_we_run = 0, ce_run = 0, setup_seen = 0;
  int          viol_wr = 0, contention = 0;
  logic [1:0]  we_lanes = 2'b11;
  logic [17:0] prev_addr = '0;
  logic        prev_we_low = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_we_n) begin
        if (we_run == 0) begin
          setup_seen = ce_run;
          we_lanes   = {mem_ub_n, mem_lb_n};
        end
        we_run++;
        if (!mem_oe_n) viol_wr++;
        if (prev_we_low && mem_addr != prev_addr) viol_wr++;
      end else if (we_run != 0) begin
        last_we_run = we_run;
        we_run = 0;
      end
      if (dq_oe != !mem_we_n) viol_wr++;
      if (dq_oe && !mem_ce_n && !mem_oe_n) contention++;
      if (!mem_ce_n && mem_we_n && we_run == 0) ce_run++;
      else if (mem_ce_n) ce_run = 0;
      prev_addr   = mem_addr;
      prev_we_low = !mem_we_n;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [17:0] a, input logic [15:0] d,
                            input logic [1:0] m, output int busy);
    @(negedge clk);
    req = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req = 1'b0;
    busy = 0;
    while (!ready) begin busy++; @(negedge clk); end
  endtask

  task automatic host_read(input logic [17:0] a, input logic [1:0] m,
                           output logic [15:0] d, output int busy,
                           output int rv_idx, output int rv_cnt, output logic [1:0] quiet);
    @(negedge clk);
    req = 1'b1; req_write = 1'b0; req_addr = a; req_mask = m;
    @(negedge clk);
    req = 1'b0;
    busy = 0; rv_idx = -1; rv_cnt = 0; d = '0; quiet = 2'b00;
    while (!ready) begin
      if (rd_valid) begin
        rv_idx = busy; rv_cnt++; d = rd_data;
        quiet = {mem_ce_n, mem_oe_n};
      end
      busy++;
      @(negedge clk);
    end
    if (rd_valid) rv_cnt++;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check("R1 ready after reset", {31'd0, ready}, 32'd1);
    check("R1 strobes after reset",
          {27'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 32'h1F);
    check("R1 drivers and valid after reset", {30'd0, dq_oe, rd_valid}, 32'd0);
  endtask

  task automatic t_full_word();
    int busy, idx, cnt; logic [15:0] d; logic [1:0] q;
    viol_wr = 0; contention = 0;
    host_write(18'h00010, 16'hA5C3, 2'b11, busy);
    check("R7 write busy cycles", busy, 4);
    check("R2 strobe width", last_we_run, 2);
    check("R2 setup cycles before strobe", setup_seen, 1);
    check("R4 drive and oe violations", viol_wr, 0);
    host_read(18'h00010, 2'b11, d, busy, idx, cnt, q);
    check("R5 full word readback", d, 16'hA5C3);
    check("R5 valid edge index", idx, 3);
    check("R5 single valid pulse", cnt, 1);
    check("R7 read busy cycles", busy, 4);
    check("R8 bus quiet at capture", q, 2'b11);
    check("R8 contention", contention, 0);
  endtask

  task automatic t_lanes();
    int busy, idx, cnt; logic [15:0] d; logic [1:0] q;
    host_write(18'h00020, 16'h1234, 2'b01, busy);
    check("R3 low-lane strobe pins {ub,lb}", we_lanes, 2'b10);
    host_read(18'h00020, 2'b11, d, busy, idx, cnt, q);
    check("R3 low lane write", d, {init_word(32'h20)}[15:8] == 0 ? 0 : {init_word(32'h20)[15:8], 8'h34});
    host_write(18'h00021, 16'h9876, 2'b10, busy);
    check("R3 high-lane strobe pins {ub,lb}", we_lanes, 2'b01);
    host_read(18'h00021, 2'b11, d, busy, idx, cnt, q);
    check("R3 high lane write", d, {8'h98, init_word(32'h21)[7:0]});
  endtask

  task automatic t_read_mask();
    int busy, idx, cnt; logic [15:0] d; logic [1:0] q;
    host_read(18'h00010, 2'b01, d, busy, idx, cnt, q);
    check("R6 low-only read", d, 16'h00C3);
    host_read(18'h00010, 2'b10, d, busy, idx, cnt, q);
    check("R6 high-only read", d, 16'hA500);
  endtask

  task automatic t_empty_mask();
    int busy, idx, cnt; logic [15:0] d; logic [1:0] q;
    host_write(18'h00030, 16'hFFFF, 2'b00, busy);
    check("R9 empty mask lanes {ub,lb}", we_lanes, 2'b11);
    host_read(18'h00030, 2'b11, d, busy, idx, cnt, q);
    check("R9 empty mask leaves word", d, init_word(32'h30));
  endtask

  task automatic t_busy_ignore();
    int busy, idx, cnt; logic [15:0] d; logic [1:0] q;
    @(negedge clk);
    req = 1'b1; req_write = 1'b1; req_addr = 18'h00040; req_wdata = 16'hBEEF; req_mask = 2'b11;
    @(negedge clk);
    req_addr = 18'h00041; req_wdata = 16'h0000;
    @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    while (!ready) @(negedge clk);
    host_read(18'h00041, 2'b11, d, busy, idx, cnt, q);
    check("R7 request while busy ignored", d, init_word(32'h41));
    host_read(18'h00040, 2'b11, d, busy, idx, cnt, q);
    check("R7 accepted write landed", d, 16'hBEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_word();
    t_lanes();
    t_read_mask();
    t_empty_mask();
    t_busy_ignore();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule